// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Unit

This block is the interrupt front end of a 32-pin port. Every pin owns a two-bit sense code, and the codes live in two 32-bit sense registers: one holds pins 0 to 15 and the other holds pins 16 to 31. Each code picks one of four behaviours for its pin: detect both edges, detect rising edges or high levels, detect falling edges or low levels, or stay silent. A single level-mode input decides whether the two one-sided codes react to edges or to levels. The two-edge code always reacts to edges.

Events are collected in a pending vector. Software clears pending bits by writing ones to the acknowledge register. A mask register selects which pending bits reach the combined interrupt line. An encoder reports which unmasked pending pin has the highest pin number. This matches a scan of the vector that starts at its least significant set bit.

Pins and vectors use MSB-first numbering: pin p sits at bit 31-p of `pinIn`, of the pending vector and of the mask. The pin samples are assumed to be synchronous to `clk`.

Top module: `irq_sense_unit`

## Requirements
- R1: After reset the pending vector, the mask and both sense registers read 0, `irqOut` and `pinValid` are 0, and the stored previous pin sample is 0.
- R2: The sense register at byte offset 0x14 serves pins 0 to 15 and the one at 0x18 serves pins 16 to 31. Pin p uses bits [s+1:s] of its register, where s = (15 - (p mod 16)) * 2.
- R3: Code 00 sets pending bit 31-p when pin p (`pinIn[31-p]`) changes in either direction. The bit shows on `pendVec` one clock edge after the first cycle that carries the new pin value. This holds in both edge mode and level mode.
- R4: In edge mode (`levelMode`=0), code 01 sets the pending bit on a rising edge only.
- R5: In edge mode, code 10 sets the pending bit on a falling edge only.
- R6: Code 11 never sets a pending bit, in either mode.
- R7: In level mode (`levelMode`=1), code 01 sets the pending bit on every cycle the pin is high, and code 10 does so on every cycle the pin is low. Acknowledging the bit therefore has no lasting effect while the level persists.
- R8: Writing to offset 0x00 clears every pending bit whose data bit is 1. Bits written as 0 are untouched. A new event in the same cycle as the acknowledge leaves its bit set.
- R9: Offset 0x04 holds the mask. `irqOut` is 1 exactly when some pending bit and its mask bit are both 1, in the same cycle.
- R10: When `irqOut` is 1, `pinValid` is 1 and `pinNum` gives the highest pin number p whose pending bit and mask bit (bit 31-p) are both 1. Otherwise `pinValid` is 0.
- R11: `rdData` returns, combinationally from `rdAddr`, the pending vector at 0x00, the mask at 0x04, and the sense registers at 0x14 and 0x18. Any other offset reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 32 | Pin samples, pin p at bit 31-p |
| levelMode | input | 1 | 1: codes 01/10 sense levels; 0: edges |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Write byte offset |
| wrData | input | 32 | Write data |
| rdAddr | input | 5 | Read byte offset |
| rdData | output | 32 | Read data |
| pendVec | output | 32 | Pending vector, pin p at bit 31-p |
| irqOut | output | 1 | Combined masked interrupt |
| pinNum | output | 5 | Highest-numbered unmasked pending pin |
| pinValid | output | 1 | `pinNum` is meaningful |

## Verification
A pin change driven after a falling clock edge reaches the pending vector at the next rising edge. The bench therefore checks `pendVec` at the following falling edge, one full cycle after the stimulus. A register write is held across exactly one rising edge, and its effect is checked at the falling edge that ends the write. `irqOut`, `pinNum`, `pinValid` and `rdData` are combinational from the registers, so they are checked in that same sampling slot, with no extra delay. The sweep covers every pin with every code in edge mode, in both directions. Level-mode persistence, acknowledge-versus-event collisions and encoder priority over several pending and mask patterns are checked separately.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int PIN_COUNT = 32;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 5;

  localparam logic [ADDR_W-1:0] OFS_PEND     = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK     = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SENSE_LO = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_SENSE_HI = 5'h18;

  typedef enum logic [1:0] {
    SENSE_BOTH = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_NONE = 2'b11
  } senseCodeT;

  typedef struct packed {
    logic             ackWr;
    logic             maskWr;
    logic             senseLoWr;
    logic             senseHiWr;
    logic [REG_W-1:0] data;
  } regStrobeT;
endpackage

// File: rtl/irq_sense_lane.sv
module irq_sense_lane
  import irq_sense_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] code,
  input  logic       levelMode,
  input  logic       pinNow,
  input  logic       pinPrev,
  output logic       hit
);
  logic riseEv;
  logic fallEv;

  assign riseEv = pinNow & ~pinPrev;
  assign fallEv = ~pinNow & pinPrev;

  always_comb begin
    unique case (senseCodeT'(code))
      SENSE_BOTH: hit = riseEv | fallEv;
      SENSE_RISE: hit = levelMode ? pinNow : riseEv;
      SENSE_FALL: hit = levelMode ? ~pinNow : fallEv;
      default:    hit = 1'b0;
    endcase
  end

  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (hit && (!levelMode || code == 2'b00)) |-> (pinNow != pinPrev)); // R3
endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
  import irq_sense_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int AW     = ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] pendQ,
  input  logic [DATA_W-1:0] maskQ,
  input  logic [DATA_W-1:0] senseLoQ,
  input  logic [DATA_W-1:0] senseHiQ,
  output regStrobeT         strobe,
  output logic [DATA_W-1:0] rdData
);
  always_comb begin
    strobe           = '0;
    strobe.data      = wrData;
    strobe.ackWr     = wrEn && (wrAddr == OFS_PEND);
    strobe.maskWr    = wrEn && (wrAddr == OFS_MASK);
    strobe.senseLoWr = wrEn && (wrAddr == OFS_SENSE_LO);
    strobe.senseHiWr = wrEn && (wrAddr == OFS_SENSE_HI);
  end

  always_comb begin
    unique case (rdAddr)
      OFS_PEND:     rdData = pendQ;
      OFS_MASK:     rdData = maskQ;
      OFS_SENSE_LO: rdData = senseLoQ;
      OFS_SENSE_HI: rdData = senseHiQ;
      default:      rdData = '0;
    endcase
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ackWr, strobe.maskWr, strobe.senseLoWr, strobe.senseHiWr})); // R11
endmodule

// File: rtl/irq_sense_datapath.sv
module irq_sense_datapath
  import irq_sense_pkg::*;
#(
  parameter int PINS = PIN_COUNT
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PINS-1:0]          pinIn,
  input  logic                     levelMode,
  input  regStrobeT                strobe,
  output logic [PINS-1:0]          pendQ,
  output logic [PINS-1:0]          maskQ,
  output logic [PINS-1:0]          senseLoQ,
  output logic [PINS-1:0]          senseHiQ,
  output logic                     irqOut,
  output logic [$clog2(PINS)-1:0]  pinNum,
  output logic                     pinValid
);
  localparam int HALF  = PINS / 2;
  localparam int NUM_W = $clog2(PINS);

  logic [PINS-1:0] pinPrev;
  logic [PINS-1:0] hitVec;
  logic [PINS-1:0] activeVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      senseLoQ <= '0;
      senseHiQ <= '0;
      maskQ    <= '0;
      pendQ    <= '0;
      pinPrev  <= '0;
    end else begin
      pinPrev <= pinIn;
      if (strobe.senseLoWr) senseLoQ <= strobe.data[PINS-1:0];
      if (strobe.senseHiWr) senseHiQ <= strobe.data[PINS-1:0];
      if (strobe.maskWr)    maskQ    <= strobe.data[PINS-1:0];
      pendQ <= (pendQ & ~({PINS{strobe.ackWr}} & strobe.data[PINS-1:0])) | hitVec;
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_lane
    localparam int BIT   = PINS - 1 - p;
    localparam int SHIFT = (HALF - 1 - (p % HALF)) * 2;
    logic [1:0] laneCode;
    if (p < HALF) begin : g_lo
      assign laneCode = senseLoQ[SHIFT +: 2];
    end else begin : g_hi
      assign laneCode = senseHiQ[SHIFT +: 2];
    end
    irq_sense_lane u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .code     (laneCode),
      .levelMode(levelMode),
      .pinNow   (pinIn[BIT]),
      .pinPrev  (pinPrev[BIT]),
      .hit      (hitVec[BIT])
    );
  end

  assign activeVec = pendQ & maskQ;
  assign irqOut    = |activeVec;

  always_comb begin
    pinNum   = '0;
    pinValid = 1'b0;
    for (int i = PINS - 1; i >= 0; i--) begin
      if (activeVec[i]) begin
        pinNum   = NUM_W'(PINS - 1 - i);
        pinValid = 1'b1;
      end
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackWr |=> ((pendQ & $past(strobe.data[PINS-1:0]) & ~$past(hitVec)) == '0)); // R8
  AST_SET_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ~$past(pendQ) & ~$past(hitVec)) == '0)); // R6
  AST_HIT_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec != '0) |=> ((pendQ & $past(hitVec)) == $past(hitVec))); // R7
endmodule

// File: rtl/irq_sense_unit.sv
module irq_sense_unit
  import irq_sense_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] pinIn,
  input  logic        levelMode,
  input  logic        wrEn,
  input  logic [4:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [4:0]  rdAddr,
  output logic [31:0] rdData,
  output logic [31:0] pendVec,
  output logic        irqOut,
  output logic [4:0]  pinNum,
  output logic        pinValid
);
  regStrobeT   strobe;
  logic [31:0] maskQ;
  logic [31:0] senseLoQ;
  logic [31:0] senseHiQ;

  irq_sense_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .pendQ   (pendVec),
    .maskQ   (maskQ),
    .senseLoQ(senseLoQ),
    .senseHiQ(senseHiQ),
    .strobe  (strobe),
    .rdData  (rdData)
  );

  irq_sense_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .levelMode(levelMode),
    .strobe   (strobe),
    .pendQ    (pendVec),
    .maskQ    (maskQ),
    .senseLoQ (senseLoQ),
    .senseHiQ (senseHiQ),
    .irqOut   (irqOut),
    .pinNum   (pinNum),
    .pinValid (pinValid)
  );

  AST_VALID_MATCHES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    pinValid == irqOut); // R10
  AST_NUM_IS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    pinValid |-> pendVec[5'd31 - pinNum]); // R10
endmodule

// File: tb/irq_sense_unit_tb.sv
module irq_sense_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinIn = '0;
  logic        levelMode = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [4:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [31:0] pendVec;
  logic        irqOut;
  logic [4:0]  pinNum;
  logic        pinValid;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_sense_unit u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .levelMode(levelMode),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .pendVec(pendVec), .irqOut(irqOut),
    .pinNum(pinNum), .pinValid(pinValid)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setPins(input logic [31:0] v);
    @(negedge clk);
    pinIn = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] fieldWord(input int p, input int c);
    int sh;
    sh = (15 - (p % 16)) * 2;
    return (32'hFFFF_FFFF & ~(32'd3 << sh)) | (32'(c) << sh);
  endfunction

  task automatic doSummary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    doSummary();
  end

  initial begin
    logic [31:0] pat;
    logic [31:0] msk;
    logic [31:0] act;
    int expNum;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pend", pendVec, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    check("R1 valid", {31'b0, pinValid}, 32'h0);
    rdAddr = 5'h04; #1 check("R1 mask", rdData, 32'h0);
    rdAddr = 5'h14; #1 check("R1 senseLo", rdData, 32'h0);
    rdAddr = 5'h18; #1 check("R1 senseHi", rdData, 32'h0);

    // R11 readback and unmapped offset
    regWrite(5'h14, 32'h1234_5678);
    regWrite(5'h18, 32'h9ABC_DEF0);
    regWrite(5'h04, 32'h0F0F_00FF);
    regWrite(5'h08, 32'hFFFF_FFFF);
    rdAddr = 5'h14; #1 check("R11 senseLo", rdData, 32'h1234_5678);
    rdAddr = 5'h18; #1 check("R11 senseHi", rdData, 32'h9ABC_DEF0);
    rdAddr = 5'h04; #1 check("R11 mask", rdData, 32'h0F0F_00FF);
    rdAddr = 5'h08; #1 check("R11 unmapped", rdData, 32'h0);
    rdAddr = 5'h00; #1 check("R11 pend", rdData, pendVec);

    // R2..R6 sweep: every pin, every code, edge mode
    regWrite(5'h04, 32'hFFFF_FFFF);
    for (int p = 0; p < 32; p++) begin
      for (int c = 0; c < 4; c++) begin
        regWrite(5'h14, (p < 16) ? fieldWord(p, c) : 32'hFFFF_FFFF);
        regWrite(5'h18, (p >= 16) ? fieldWord(p, c) : 32'hFFFF_FFFF);
        setPins(32'h1 << (31 - p));
        check($sformatf("R2 R3 R4 R6 rise pin%0d code%0d", p, c), pendVec,
              ((c == 0) || (c == 1)) ? (32'h1 << (31 - p)) : 32'h0);
        regWrite(5'h00, 32'hFFFF_FFFF);
        setPins(32'h0);
        check($sformatf("R2 R3 R5 R6 fall pin%0d code%0d", p, c), pendVec,
              ((c == 0) || (c == 2)) ? (32'h1 << (31 - p)) : 32'h0);
        regWrite(5'h00, 32'hFFFF_FFFF);
      end
    end

    // R8 partial acknowledge and set-beats-clear
    regWrite(5'h14, 32'h0);
    regWrite(5'h18, 32'h0);
    setPins(32'hA000_0003);
    check("R8 setup", pendVec, 32'hA000_0003);
    regWrite(5'h00, 32'h2000_0001);
    check("R8 partial ack", pendVec, 32'h8000_0002);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'h00; wrData = 32'hFFFF_FFFF; pinIn = 32'hA000_0002;
    @(negedge clk);
    wrEn = 1'b0;
    check("R8 event beats ack", pendVec, 32'h0000_0001);
    setPins(32'h0);
    regWrite(5'h00, 32'hFFFF_FFFF);

    // R7 level mode
    regWrite(5'h14, fieldWord(5, 1));
    regWrite(5'h18, fieldWord(18, 2));
    levelMode = 1'b1;
    @(negedge clk);
    check("R7 low level pin18", pendVec, 32'h1 << 13);
    setPins(32'h1 << 26);
    regWrite(5'h00, 32'hFFFF_FFFF);
    check("R7 level persists", pendVec, (32'h1 << 26) | (32'h1 << 13));
    setPins(32'h1 << 13);
    regWrite(5'h00, 32'hFFFF_FFFF);
    check("R7 level gone", pendVec, 32'h0);
    // R3 code 00 stays edge-only in level mode
    regWrite(5'h14, fieldWord(2, 0));
    regWrite(5'h18, 32'hFFFF_FFFF);
    setPins(32'h1 << 29);
    check("R3 level-mode edge", pendVec, 32'h1 << 29);
    regWrite(5'h00, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R3 no repeat while high", pendVec, 32'h0);
    setPins(32'h0);
    regWrite(5'h00, 32'hFFFF_FFFF);
    levelMode = 1'b0;

    // R9 R10 mask and encoder patterns
    regWrite(5'h14, 32'h0);
    regWrite(5'h18, 32'h0);
    pat = 32'h1357_9BDF;
    msk = 32'hF0F0_3C3C;
    for (int k = 0; k < 12; k++) begin
      pat = {pat[30:0], pat[31] ^ pat[21] ^ pat[1] ^ pat[0]};
      msk = {msk[28:0], msk[31:29]} ^ 32'h0101_0001;
      if (k == 11) msk = 32'h0;
      regWrite(5'h04, msk);
      setPins(pat);
      act = pat & msk;
      expNum = 0;
      for (int p = 0; p < 32; p++) if (act[31 - p]) expNum = p;
      check($sformatf("R9 pend k%0d", k), pendVec, pat);
      check($sformatf("R9 irq k%0d", k), {31'b0, irqOut}, {31'b0, |act});
      check($sformatf("R10 valid k%0d", k), {31'b0, pinValid}, {31'b0, |act});
      if (|act) check($sformatf("R10 num k%0d", k), {27'b0, pinNum}, 32'(expNum));
      setPins(32'h0);
      regWrite(5'h00, 32'hFFFF_FFFF);
    end
    doSummary();
  end
endmodule